// File: doc/BRIEF.md
# Paged Address Translator with Associative Lookup

This block turns a logical address into a physical address under a paged memory scheme. The upper bits of the logical address select a page and the lower bits are an offset within it. A small fully associative store keeps recent page-to-frame mappings. When it holds the page, the physical address comes back one cycle after the request. When it does not, the block reads the page table entry from memory through a request/response read port, fills an associative entry and then completes the translation.

Before any lookup, the page is checked against a software-loaded limit that holds the highest legal page. Requests beyond the limit trap at once. Each entry read from the table carries a frame number, a validity flag and a write-permission flag. Invalid entries and writes to pages without write permission raise their own trap codes. Loading a new table base empties the associative store. When the store is full, the least recently used entry is replaced.

Top module: `page_xlate`

## Requirements
- R1: The page number is bits [LA_W-1:OFF_W] of `laddr_i`, which is the address divided by the page size. The offset is bits [OFF_W-1:0], which is the remainder.
- R2: The physical address `paddr_o` is the frame number in its upper FR_W bits, joined with the unchanged offset in its lower OFF_W bits.
- R3: A request whose page is held in the associative store raises `done_o` for one cycle, on the clock edge after the request, and issues no memory read.
- R4: If the page number is greater than the loaded limit, `done_o` is raised on the next edge with `trap_o` = 1 (bound trap), and no lookup or memory read is made. A page equal to the limit is legal.
- R5: On a miss, `mem_req_o` rises on the edge after the request, with `mem_addr_o` = table base + page number. It stays high with a stable address until `mem_rvalid_i` is seen, and `done_o` stays low in the meantime.
- R6: `done_o` pulses on the edge after `mem_rvalid_i` is sampled high, and `mem_req_o` falls on that same edge.
- R7: A table entry is laid out as {frame[FR_W-1:0], valid (bit 1), writable (bit 0)}. An entry with valid = 0 gives `trap_o` = 2 (invalid trap) and is not cached, so a repeat access reads memory again.
- R8: A write (`wr_i` = 1) to a page whose writable bit is 0 gives `trap_o` = 3 (protection trap), on both a hit and a miss. Reads of such a page complete with `trap_o` = 0. Valid read-only entries are cached.
- R9: A pulse on `base_ld_i` loads `base_i` as the table base and empties every associative entry, so the next access to any page misses.
- R10: When every entry is in use, a fill evicts the entry with the smallest recency stamp, which is the least recently hit or filled.
- R11: At most one associative entry matches any page number.
- R12: After reset, `done_o`, `mem_req_o` and `trap_o` are 0, the base and limit are 0, and the associative store is empty.
- R13: `req_i` is ignored while a memory read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a translation (one-cycle pulse) |
| laddr_i | input | LA_W | Logical address |
| wr_i | input | 1 | Access type: 1 write, 0 read |
| base_ld_i | input | 1 | Load the table base and flush the associative store |
| base_i | input | MA_W | Table base value |
| lim_ld_i | input | 1 | Load the page limit |
| lim_i | input | PN_W | Highest legal page number |
| mem_req_o | output | 1 | Table entry read request |
| mem_addr_o | output | MA_W | Table entry address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | FR_W+2 | Table entry {frame, valid, writable} |
| done_o | output | 1 | Translation finished (one-cycle pulse) |
| paddr_o | output | FR_W+OFF_W | Physical address |
| trap_o | output | 2 | 0 none, 1 bound, 2 invalid, 3 protection |

## Verification
Assertions check on every cycle that no two entries match one page, that the recency stamps keep exactly one oldest entry, and that hits and bound traps finish on the next edge without a memory read. They also check that an outstanding read holds its address until the response arrives, that the response is followed by a done pulse, and that an invalid entry leads to the invalid trap. Only the bench's scenarios can show that the right physical addresses come out, which entry is evicted after a given access history, that a base load forces later misses, that invalid entries are not kept, and that a request made during a walk has no effect.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    TRAP_NONE    = 2'd0,
    TRAP_BOUND   = 2'd1,
    TRAP_INVALID = 2'd2,
    TRAP_PROT    = 2'd3
  } trap_e;
endpackage

// File: rtl/pt_cam.sv
module pt_cam #(
  parameter int N_ENT = 8,
  parameter int PN_W  = 6,
  parameter int FR_W  = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [PN_W-1:0]  lk_page_i,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [PN_W-1:0]  fill_page_i,
  input  logic [FR_W-1:0]  fill_frame_i,
  input  logic             fill_wr_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o,
  output logic [FR_W-1:0]  hit_frame_o,
  output logic             hit_wr_o,
  output logic             full_o,
  output logic [IDX_W-1:0] free_idx_o
);
  logic [N_ENT-1:0] vld_q;
  logic [PN_W-1:0]  pg_q  [N_ENT];
  logic [FR_W-1:0]  fr_q  [N_ENT];
  logic [N_ENT-1:0] wr_q;
  logic [N_ENT-1:0] match;

  // parallel compare of every entry
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (pg_q[g] == lk_page_i);
  end

  always_comb begin
    hit_idx_o   = '0;
    hit_frame_o = '0;
    hit_wr_o    = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (match[i]) begin
        hit_idx_o   = IDX_W'(i);
        hit_frame_o = fr_q[i];
        hit_wr_o    = wr_q[i];
      end
    end
  end

  always_comb begin
    free_idx_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx_o = IDX_W'(i);
    end
  end

  assign hit_o  = |match;
  assign full_o = &vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      wr_q  <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        pg_q[i] <= '0;
        fr_q[i] <= '0;
      end
    end else if (flush_i) begin
      vld_q <= '0;
    end else if (fill_i) begin
      vld_q[fill_idx_i] <= 1'b1;
      pg_q[fill_idx_i]  <= fill_page_i;
      fr_q[fill_idx_i]  <= fill_frame_i;
      wr_q[fill_idx_i]  <= fill_wr_i;
    end
  end

  assert_single_match_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/pt_lru.sv
module pt_lru #(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] lru_idx_o
);
  logic [IDX_W-1:0] stamp_q [N_ENT];
  logic [N_ENT-1:0] oldest;

  for (genvar g = 0; g < N_ENT; g++) begin : g_old
    assign oldest[g] = (stamp_q[g] == '0);
  end

  always_comb begin
    lru_idx_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (oldest[i]) lru_idx_o = IDX_W'(i);
    end
  end

  // touched entry takes the top stamp; newer ones shift down by one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) stamp_q[i] <= IDX_W'(i);
    end else if (flush_i) begin
      for (int i = 0; i < N_ENT; i++) stamp_q[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N_ENT; i++) begin
        if (IDX_W'(i) == touch_idx_i)
          stamp_q[i] <= IDX_W'(N_ENT - 1);
        else if (stamp_q[i] > stamp_q[touch_idx_i])
          stamp_q[i] <= stamp_q[i] - 1'b1;
      end
    end
  end

  assert_one_oldest_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(oldest) == 1);
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import pt_pkg::*;
#(
  parameter int PN_W  = 6,
  parameter int OFF_W = 4,
  parameter int FR_W  = 8,
  parameter int MA_W  = 12,
  parameter int N_ENT = 8,
  localparam int LA_W  = PN_W + OFF_W,
  localparam int PA_W  = FR_W + OFF_W,
  localparam int PTE_W = FR_W + 2,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [LA_W-1:0]  laddr_i,
  input  logic             wr_i,
  input  logic             base_ld_i,
  input  logic [MA_W-1:0]  base_i,
  input  logic             lim_ld_i,
  input  logic [PN_W-1:0]  lim_i,
  output logic             mem_req_o,
  output logic [MA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             done_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic [1:0]       trap_o
);
  logic [MA_W-1:0]  base_q;
  logic [PN_W-1:0]  lim_q;
  logic             busy_q;
  logic [PN_W-1:0]  wpage_q;
  logic [OFF_W-1:0] woff_q;
  logic             wwr_q;

  logic [PN_W-1:0]  pn;
  logic [OFF_W-1:0] off;
  logic             accept, in_bound;
  logic             hit, hit_wr, full;
  logic [IDX_W-1:0] hit_idx, free_idx, lru_idx, victim;
  logic [FR_W-1:0]  hit_frame;
  logic             resp, pte_vld, pte_wr, fill;
  logic [FR_W-1:0]  pte_frame;
  logic             touch;
  logic [IDX_W-1:0] touch_idx;

  assign pn       = laddr_i[LA_W-1:OFF_W];
  assign off      = laddr_i[OFF_W-1:0];
  assign accept   = req_i && !busy_q;
  assign in_bound = (pn <= lim_q);

  assign resp      = busy_q && mem_rvalid_i;
  assign pte_frame = mem_rdata_i[PTE_W-1:2];
  assign pte_vld   = mem_rdata_i[1];
  assign pte_wr    = mem_rdata_i[0];
  assign fill      = resp && pte_vld;
  assign victim    = full ? lru_idx : free_idx;

  assign touch     = fill || (accept && in_bound && hit);
  assign touch_idx = fill ? victim : hit_idx;

  pt_cam #(.N_ENT(N_ENT), .PN_W(PN_W), .FR_W(FR_W)) u_cam (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (base_ld_i),
    .lk_page_i    (pn),
    .fill_i       (fill),
    .fill_idx_i   (victim),
    .fill_page_i  (wpage_q),
    .fill_frame_i (pte_frame),
    .fill_wr_i    (pte_wr),
    .hit_o        (hit),
    .hit_idx_o    (hit_idx),
    .hit_frame_o  (hit_frame),
    .hit_wr_o     (hit_wr),
    .full_o       (full),
    .free_idx_o   (free_idx)
  );

  pt_lru #(.N_ENT(N_ENT)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (base_ld_i),
    .touch_i     (touch),
    .touch_idx_i (touch_idx),
    .lru_idx_o   (lru_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      lim_q  <= '0;
    end else begin
      if (base_ld_i) base_q <= base_i;
      if (lim_ld_i)  lim_q  <= lim_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      wpage_q    <= '0;
      woff_q     <= '0;
      wwr_q      <= 1'b0;
      mem_req_o  <= 1'b0;
      mem_addr_o <= '0;
      done_o     <= 1'b0;
      paddr_o    <= '0;
      trap_o     <= TRAP_NONE;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        if (!in_bound) begin
          done_o  <= 1'b1;
          paddr_o <= '0;
          trap_o  <= TRAP_BOUND;
        end else if (hit) begin
          done_o  <= 1'b1;
          paddr_o <= {hit_frame, off};
          trap_o  <= (wr_i && !hit_wr) ? TRAP_PROT : TRAP_NONE;
        end else begin
          busy_q     <= 1'b1;
          mem_req_o  <= 1'b1;
          mem_addr_o <= base_q + MA_W'(pn);
          wpage_q    <= pn;
          woff_q     <= off;
          wwr_q      <= wr_i;
        end
      end else if (resp) begin
        busy_q    <= 1'b0;
        mem_req_o <= 1'b0;
        done_o    <= 1'b1;
        paddr_o   <= {pte_frame, woff_q};
        if (!pte_vld)              trap_o <= TRAP_INVALID;
        else if (wwr_q && !pte_wr) trap_o <= TRAP_PROT;
        else                       trap_o <= TRAP_NONE;
      end
    end
  end

  assert_hit_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_bound && hit) |=> (done_o && !mem_req_o));

  assert_bound_trap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !in_bound) |=> (done_o && trap_o == TRAP_BOUND && !mem_req_o));

  assert_walk_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o) && !done_o));

  assert_walk_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i) |=> (done_o && !mem_req_o));

  assert_invalid_trap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i && !mem_rdata_i[1]) |=> (trap_o == TRAP_INVALID));
endmodule

// File: tb/sim_page_xlate.sv
`timescale 1ns/1ps
module sim_page_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [9:0]  laddr = '0;
  logic        wr = 1'b0;
  logic        base_ld = 1'b0;
  logic [11:0] base = '0;
  logic        lim_ld = 1'b0;
  logic [5:0]  lim = '0;
  logic        mem_req;
  logic [11:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [9:0]  mem_rdata = '0;
  logic        done;
  logic [11:0] paddr;
  logic [1:0]  trap;

  int checks = 0;
  int fails  = 0;
  logic [11:0] cur_base = '0;

  always #4 clk = ~clk;

  page_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .laddr_i(laddr), .wr_i(wr),
    .base_ld_i(base_ld), .base_i(base), .lim_ld_i(lim_ld), .lim_i(lim),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .done_o(done), .paddr_o(paddr), .trap_o(trap)
  );

  typedef struct packed {
    logic [5:0] page;
    logic [3:0] off;
    logic       wr;
    logic       miss;
    logic [9:0] pte;   // {frame, valid, writable}
    logic [1:0] trap;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{6'd3,  4'h5, 1'b0, 1'b1, 10'h08F, 2'd0},
    '{6'd3,  4'hA, 1'b1, 1'b0, 10'h08F, 2'd0},
    '{6'd20, 4'h1, 1'b0, 1'b1, 10'h113, 2'd0},
    '{6'd21, 4'h2, 1'b0, 1'b0, 10'h000, 2'd1},
    '{6'd5,  4'h7, 1'b1, 1'b1, 10'h156, 2'd3},
    '{6'd5,  4'h8, 1'b0, 1'b0, 10'h156, 2'd0},
    '{6'd5,  4'h9, 1'b1, 1'b0, 10'h156, 2'd3},
    '{6'd6,  4'h3, 1'b0, 1'b1, 10'h000, 2'd2},
    '{6'd6,  4'h4, 1'b0, 1'b1, 10'h19B, 2'd0},
    '{6'd0,  4'hF, 1'b0, 1'b1, 10'h043, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_base(input logic [11:0] v);
    @(negedge clk); base_ld = 1'b1; base = v;
    @(negedge clk); base_ld = 1'b0;
    cur_base = v;
  endtask

  task automatic set_lim(input logic [5:0] v);
    @(negedge clk); lim_ld = 1'b1; lim = v;
    @(negedge clk); lim_ld = 1'b0;
  endtask

  // one translation; for a miss, answer after dly idle cycles
  task automatic xl(input string tag, input logic [5:0] pg, input logic [3:0] of,
                    input logic w, input logic miss, input logic [9:0] pte,
                    input logic [1:0] etrap, input int dly);
    @(negedge clk); req = 1'b1; laddr = {pg, of}; wr = w;
    @(negedge clk); req = 1'b0;
    if (miss) begin
      chk({tag, " R5 mem_req"}, 32'(mem_req), 32'd1);
      chk({tag, " R5 no done"}, 32'(done), 32'd0);
      chk({tag, " R5 mem_addr"}, 32'(mem_addr), 32'(cur_base + 12'(pg)));
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        chk({tag, " R5 hold"}, 32'({mem_req, done, mem_addr}), 32'({1'b1, 1'b0, cur_base + 12'(pg)}));
      end
      mem_rvalid = 1'b1; mem_rdata = pte;
      @(negedge clk); mem_rvalid = 1'b0; mem_rdata = '0;
      chk({tag, " R6 req drop"}, 32'(mem_req), 32'd0);
    end else begin
      chk({tag, " R3 no mem_req"}, 32'(mem_req), 32'd0);
    end
    chk({tag, " R6 done"}, 32'(done), 32'd1);
    chk({tag, " R4 R7 R8 trap"}, 32'(trap), 32'(etrap));
    if (etrap == 2'd0 || etrap == 2'd3)
      chk({tag, " R1 R2 paddr"}, 32'(paddr), 32'({pte[9:2], of}));
    @(negedge clk);
    chk({tag, " done pulse"}, 32'(done), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 done", 32'(done), 32'd0);
    chk("R12 mem_req", 32'(mem_req), 32'd0);
    chk("R12 trap", 32'(trap), 32'd0);
    rst_n = 1'b1;
    set_base(12'h100);
    set_lim(6'd20);

    for (int v = 0; v < NV; v++)
      xl($sformatf("vec%0d", v), VEC[v].page, VEC[v].off, VEC[v].wr,
         VEC[v].miss, VEC[v].pte, VEC[v].trap, v % 3);

    // R7 invalid not cached: page 6 now cached after valid fill, page 0 too
    xl("R7 cached after valid", 6'd6, 4'h1, 1'b0, 1'b0, 10'h19B, 2'd0, 0);

    // R9 base load flushes
    set_base(12'h200);
    xl("R9 flush page3", 6'd3, 4'h2, 1'b0, 1'b1, 10'h08F, 2'd0, 0);
    xl("R9 flush page6", 6'd6, 4'h2, 1'b0, 1'b1, 10'h19B, 2'd0, 1);

    // R13 request during walk ignored
    @(negedge clk); req = 1'b1; laddr = {6'd7, 4'h6}; wr = 1'b0;
    @(negedge clk); laddr = {6'd3, 4'h1};
    chk("R13 walk start", 32'(mem_req), 32'd1);
    @(negedge clk); req = 1'b0;
    chk("R13 no done", 32'(done), 32'd0);
    chk("R13 addr stable", 32'(mem_addr), 32'(12'h207));
    mem_rvalid = 1'b1; mem_rdata = 10'h1C3;
    @(negedge clk); mem_rvalid = 1'b0; mem_rdata = '0;
    chk("R13 done", 32'(done), 32'd1);
    chk("R13 paddr", 32'(paddr), 32'({8'h70, 4'h6}));
    @(negedge clk);
    chk("R13 single done", 32'(done), 32'd0);

    // R4 limit edges
    set_lim(6'd63);
    xl("R4 top page legal", 6'd63, 4'h0, 1'b0, 1'b1, 10'h3FF, 2'd0, 0);
    set_lim(6'd8);
    xl("R4 over limit", 6'd9, 4'h0, 1'b0, 1'b0, 10'h000, 2'd1, 0);
    xl("R4 over limit cached", 6'd63, 4'h0, 1'b0, 1'b0, 10'h000, 2'd1, 0);

    // R10 LRU eviction
    set_lim(6'd20);
    set_base(12'h300);
    for (int p = 1; p <= 8; p++)
      xl("R10 fill", 6'(p), 4'h0, 1'b0, 1'b1, {8'(p + 8'h20), 2'b11}, 2'd0, 0);
    xl("R10 touch p1", 6'd1, 4'h1, 1'b0, 1'b0, {8'h21, 2'b11}, 2'd0, 0);
    xl("R10 evict p2", 6'd9, 4'h1, 1'b0, 1'b1, {8'h29, 2'b11}, 2'd0, 0);
    xl("R10 p1 kept", 6'd1, 4'h2, 1'b0, 1'b0, {8'h21, 2'b11}, 2'd0, 0);
    xl("R10 p2 gone", 6'd2, 4'h2, 1'b0, 1'b1, {8'h22, 2'b11}, 2'd0, 0);
    xl("R10 p4 kept", 6'd4, 4'h2, 1'b0, 1'b0, {8'h24, 2'b11}, 2'd0, 0);
    xl("R10 p3 gone", 6'd3, 4'h2, 1'b0, 1'b1, {8'h23, 2'b11}, 2'd0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule